// File: doc/BRIEF.md
# Vector Lane Shuffle with Write Masking

This datapath block forms a 512-bit result out of four 128-bit lanes taken from two vector sources. An 8-bit selector chooses the lanes. The lower half of the result draws only on the first source and the upper half only on the second. When the second source is marked as coming from memory and broadcast is asked for, its lowest element (32 or 64 bits) is first copied into every element position.

After the lane choice, a per-element write mask is applied. Each element either takes the shuffled value, keeps the old destination value (merge mode) or is cleared (zeroing mode). Two vector lengths are legal, 256 and 512 bits. Any other length code raises an error flag and leaves the output untouched. The element-size control changes only the broadcast width and the mask granularity, so integer and floating-point variants run on the same logic.

The result is registered. It appears one clock after the input strobe, together with a one-cycle valid pulse.

Top module: `lane_shuffle_unit`

## Requirements
- R1: With `vl_sel`=2'b10 (512 bits), result lane 0 (bits 127:0) is lane `sel_imm[1:0]` of `src_a`, and result lane 1 (bits 255:128) is lane `sel_imm[3:2]` of `src_a`. Lane n of a source is its bits [128n+127:128n].
- R2: With 512 bits, result lane 2 is lane `sel_imm[5:4]` and result lane 3 is lane `sel_imm[7:6]` of the (possibly broadcast) second source.
- R3: With `vl_sel`=2'b01 (256 bits), result bits 127:0 are lane `sel_imm[0]` of `src_a`, and result bits 255:128 are lane `sel_imm[1]` of the second source. `sel_imm[7:2]` has no effect.
- R4: When `bcast`=1 and `b_from_mem`=1, every element of `src_b` is replaced by `src_b`'s lowest element before lane choice. That element is 32 bits when `esz_64`=0 and 64 bits when `esz_64`=1. If either flag is 0, `src_b` is used unchanged.
- R5: Element i is bits [32i+31:32i] when `esz_64`=0, or [64i+63:64i] when `esz_64`=1, and is governed by `wmask[i]`. 512 bits has 16 or 8 elements and 256 bits has 8 or 4. Mask bits above the active element count have no effect.
- R6: An element takes the shuffled value when `mask_en`=0 or its mask bit is 1. Otherwise it takes the `old_dst` element when `zero_mode`=0, and zero when `zero_mode`=1.
- R7: Result bits above the active vector length are always zero.
- R8: `vl_sel`=2'b00 (128 bits) and 2'b11 are illegal. A strobe with an illegal length sets `len_err` for one cycle, leaves `res` unchanged and gives no `res_valid`.
- R9: `res` and `res_valid` update on the rising edge that samples `in_valid`=1. `res_valid` is high for one cycle per strobe, and `res` holds when there is no strobe.
- R10: A synchronous active-high `rst` clears `res`, `res_valid` and `len_err`.
- R11: `esz_64` has no effect on the result when broadcast is off and masking is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| src_a | input | 512 | First source vector |
| src_b | input | 512 | Second source vector |
| old_dst | input | 512 | Previous destination value for merging |
| sel_imm | input | 8 | Lane selector |
| wmask | input | 16 | Per-element write mask |
| mask_en | input | 1 | 1 = apply write mask |
| zero_mode | input | 1 | 1 = zero unselected elements, 0 = merge |
| bcast | input | 1 | Broadcast request for second source |
| b_from_mem | input | 1 | Second source comes from memory |
| vl_sel | input | 2 | Vector length: 01 = 256, 10 = 512, others illegal |
| esz_64 | input | 1 | Element size: 1 = 64-bit, 0 = 32-bit |
| res | output | 512 | Registered result |
| res_valid | output | 1 | Result valid pulse |
| len_err | output | 1 | Illegal vector length pulse |

## Verification
The bench targets the points where a lane selector is easy to get wrong:
- A mix of all four lane codes in 512-bit mode catches swapped selector fields or an upper half fed from the wrong source.
- In 256-bit mode, junk in the upper selector bits and in the upper mask bits catches a design that decodes them.
- An upper half left nonzero in 256-bit mode is also flagged.
- Broadcast is tried at both element sizes and with the memory flag clear, which exposes broadcasting from register operands or copying the wrong width.
- Merge and zeroing masks at both granularities catch a mask bit indexed per 32-bit word when elements are 64 bits.
- An illegal length after a good result catches a design that overwrites or validates the output.

// File: rtl/lsh_pkg.sv
package lsh_pkg;
  typedef enum logic [1:0] {
    VL_128  = 2'b00,
    VL_256  = 2'b01,
    VL_512  = 2'b10,
    VL_RSVD = 2'b11
  } vlen_e;

  function automatic logic vl_is_legal(input logic [1:0] code);
    return (code == VL_256) || (code == VL_512);
  endfunction
endpackage

// File: rtl/lsh_bcast.sv
module lsh_bcast #(
  parameter int VEC_W   = 512,
  parameter int CHUNK_W = 32
) (
  input  logic [VEC_W-1:0] src,
  input  logic             bcast,
  input  logic             from_mem,
  input  logic             esz_64,
  output logic [VEC_W-1:0] dst
);
  localparam int NCHUNK = VEC_W / CHUNK_W;

  logic do_bc;
  assign do_bc = bcast & from_mem;

  for (genvar k = 0; k < NCHUNK; k++) begin : g_chunk
    logic [CHUNK_W-1:0] wide_pick;
    assign wide_pick = src[(k % 2)*CHUNK_W +: CHUNK_W];
    assign dst[k*CHUNK_W +: CHUNK_W] =
      !do_bc ? src[k*CHUNK_W +: CHUNK_W] :
      (esz_64 ? wide_pick : src[CHUNK_W-1:0]);
  end
endmodule

// File: rtl/lsh_lane_sel.sv
module lsh_lane_sel #(
  parameter int VEC_W  = 512,
  parameter int LANE_W = 128,
  parameter int IMM_W  = 8
) (
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  input  logic [IMM_W-1:0] imm,
  input  logic             wide,
  output logic [VEC_W-1:0] y
);
  localparam int NLANES = VEC_W / LANE_W;
  localparam int HALF   = NLANES / 2;
  localparam int SELW   = $clog2(NLANES);
  localparam int NSELW  = SELW - 1;

  function automatic logic [LANE_W-1:0] pick_lane(input logic [VEC_W-1:0] v,
                                                  input logic [SELW-1:0] idx);
    return v[idx*LANE_W +: LANE_W];
  endfunction

  for (genvar r = 0; r < NLANES; r++) begin : g_lane
    logic [SELW-1:0]   idx_w;
    logic [SELW-1:0]   idx_n;
    logic [LANE_W-1:0] lane_w;
    logic [LANE_W-1:0] lane_n;
    assign idx_w  = imm[r*SELW +: SELW];
    assign lane_w = (r < HALF) ? pick_lane(a, idx_w) : pick_lane(b, idx_w);
    if (r < HALF) begin : g_narrow
      assign idx_n  = {1'b0, imm[r*NSELW +: NSELW]};
      assign lane_n = (r < HALF/2) ? pick_lane(a, idx_n) : pick_lane(b, idx_n);
    end else begin : g_dead
      assign idx_n  = '0;
      assign lane_n = '0;
    end
    assign y[r*LANE_W +: LANE_W] = wide ? lane_w : lane_n;
  end
endmodule

// File: rtl/lsh_mask.sv
module lsh_mask #(
  parameter int VEC_W   = 512,
  parameter int CHUNK_W = 32
) (
  input  logic [VEC_W-1:0]          shuf,
  input  logic [VEC_W-1:0]          old,
  input  logic [VEC_W/CHUNK_W-1:0]  wmask,
  input  logic                      mask_en,
  input  logic                      zero_mode,
  input  logic                      esz_64,
  input  logic                      wide,
  output logic [VEC_W-1:0]          y
);
  localparam int NCHUNK = VEC_W / CHUNK_W;

  for (genvar k = 0; k < NCHUNK; k++) begin : g_chunk
    logic active;
    logic mbit;
    logic keep;
    assign active = wide || (k < NCHUNK/2);
    assign mbit   = esz_64 ? wmask[k/2] : wmask[k];
    assign keep   = ~mask_en | mbit;
    assign y[k*CHUNK_W +: CHUNK_W] =
      !active ? '0 :
      keep    ? shuf[k*CHUNK_W +: CHUNK_W] :
      (zero_mode ? '0 : old[k*CHUNK_W +: CHUNK_W]);
  end
endmodule

// File: rtl/lane_shuffle_unit.sv
module lane_shuffle_unit #(
  parameter int VEC_W   = 512,
  parameter int LANE_W  = 128,
  parameter int CHUNK_W = 32,
  parameter int IMM_W   = 8,
  localparam int MASK_W = VEC_W / CHUNK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [VEC_W-1:0]  src_a,
  input  logic [VEC_W-1:0]  src_b,
  input  logic [VEC_W-1:0]  old_dst,
  input  logic [IMM_W-1:0]  sel_imm,
  input  logic [MASK_W-1:0] wmask,
  input  logic              mask_en,
  input  logic              zero_mode,
  input  logic              bcast,
  input  logic              b_from_mem,
  input  logic [1:0]        vl_sel,
  input  logic              esz_64,
  output logic [VEC_W-1:0]  res,
  output logic              res_valid,
  output logic              len_err
);
  import lsh_pkg::*;

  localparam int HALF_W = VEC_W / 2;

  logic             wide;
  logic             take_cycle;
  logic             reject_cycle;
  logic [VEC_W-1:0] b_eff;
  logic [VEC_W-1:0] shuf_res;
  logic [VEC_W-1:0] masked_res;

  assign wide         = (vl_sel == VL_512);
  assign take_cycle   = in_valid &  vl_is_legal(vl_sel);
  assign reject_cycle = in_valid & ~vl_is_legal(vl_sel);

  lsh_bcast #(.VEC_W(VEC_W), .CHUNK_W(CHUNK_W)) u_bcast (
    .src(src_b), .bcast(bcast), .from_mem(b_from_mem), .esz_64(esz_64), .dst(b_eff)
  );

  lsh_lane_sel #(.VEC_W(VEC_W), .LANE_W(LANE_W), .IMM_W(IMM_W)) u_sel (
    .a(src_a), .b(b_eff), .imm(sel_imm), .wide(wide), .y(shuf_res)
  );

  lsh_mask #(.VEC_W(VEC_W), .CHUNK_W(CHUNK_W)) u_mask (
    .shuf(shuf_res), .old(old_dst), .wmask(wmask), .mask_en(mask_en),
    .zero_mode(zero_mode), .esz_64(esz_64), .wide(wide), .y(masked_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res       <= '0;
      res_valid <= 1'b0;
      len_err   <= 1'b0;
    end else begin
      res_valid <= take_cycle;
      len_err   <= reject_cycle;
      if (take_cycle) res <= masked_res;
    end
  end

  // R8
  illegal_hold_chk: assert property (@(posedge clk) disable iff (rst)
    len_err |-> ($stable(res) && !res_valid));

  // R9
  valid_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(in_valid));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> $stable(res));

  // R7
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(vl_sel) == VL_256) |-> (res[VEC_W-1:HALF_W] == '0));

  // R6
  all_zeroed_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(mask_en && zero_mode && wmask == '0)) |-> (res == '0));
endmodule

// File: tb/sim_lane_shuffle_unit.sv
module sim_lane_shuffle_unit;
  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [511:0] src_a, src_b, old_dst;
  logic [7:0]   sel_imm;
  logic [15:0]  wmask;
  logic         mask_en, zero_mode, bcast, b_from_mem, esz_64;
  logic [1:0]   vl_sel;
  logic [511:0] res;
  logic         res_valid, len_err;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  lane_shuffle_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src_a(src_a), .src_b(src_b),
    .old_dst(old_dst), .sel_imm(sel_imm), .wmask(wmask), .mask_en(mask_en),
    .zero_mode(zero_mode), .bcast(bcast), .b_from_mem(b_from_mem),
    .vl_sel(vl_sel), .esz_64(esz_64), .res(res), .res_valid(res_valid),
    .len_err(len_err)
  );

  function automatic logic [511:0] model(
    input logic [511:0] a, input logic [511:0] b, input logic [511:0] od,
    input logic [7:0] imm, input logic [15:0] m, input logic men, input logic zm,
    input logic bc, input logic mem, input logic [1:0] vl, input logic e64);
    logic [511:0] bb, out;
    bb = b;
    if (bc && mem)
      for (int w = 0; w < 16; w++)
        bb[w*32 +: 32] = e64 ? b[(w % 2)*32 +: 32] : b[31:0];
    out = '0;
    for (int w = 0; w < 16; w++) begin
      int lane, sub, idx, elem, cnt;
      logic [511:0] s;
      logic [31:0] v;
      lane = w / 4; sub = w % 4;
      cnt  = ((vl == 2'b10) ? 16 : 8) / (e64 ? 2 : 1);
      elem = e64 ? w / 2 : w;
      if (vl == 2'b10) begin
        s = (lane < 2) ? a : bb;
        idx = int'(imm[lane*2 +: 2]);
      end else begin
        s = (lane == 0) ? a : bb;
        idx = (lane < 2) ? int'(imm[lane]) : 0;
      end
      v = s[(idx*4 + sub)*32 +: 32];
      if (vl != 2'b10 && lane >= 2) v = '0;
      else if (men && !(elem < cnt && m[elem])) v = zm ? 32'h0 : od[w*32 +: 32];
      out[w*32 +: 32] = v;
    end
    return out;
  endfunction

  task automatic chk_vec(input string req, input logic [511:0] act, input logic [511:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s res act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_bit(input string req, input string what, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%b exp=%b", req, what, act, exp);
    end
  endtask

  task automatic set_defaults();
    for (int w = 0; w < 16; w++) begin
      src_a[w*32 +: 32]   = {16'hA0A0, 12'h000, 4'(w)};
      src_b[w*32 +: 32]   = {16'hB1B1, 12'h000, 4'(w)};
      old_dst[w*32 +: 32] = {16'hD2D2, 12'h000, 4'(w)};
    end
    sel_imm = '0; wmask = '0; mask_en = 0; zero_mode = 0;
    bcast = 0; b_from_mem = 0; vl_sel = 2'b10; esz_64 = 0;
  endtask

  // one strobe, then check at the following negedge
  task automatic fire(input string req);
    logic [511:0] exp;
    exp = model(src_a, src_b, old_dst, sel_imm, wmask, mask_en, zero_mode,
                bcast, b_from_mem, vl_sel, esz_64);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk_vec(req, res, exp);
    chk_bit(req, "res_valid", res_valid, 1'b1);
    chk_bit(req, "len_err", len_err, 1'b0);
  endtask

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b0; set_defaults();
    repeat (2) @(negedge clk);
    chk_vec("R10", res, '0);
    chk_bit("R10", "res_valid", res_valid, 1'b0);
    chk_bit("R10", "len_err", len_err, 1'b0);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_full_lanes();
    set_defaults();
    sel_imm = 8'b01_10_11_00; fire("R1");
    sel_imm = 8'b11_00_01_10; fire("R2");
    sel_imm = 8'b00_11_10_01; fire("R1");
    sel_imm = 8'hFF;          fire("R2");
  endtask

  task automatic t_half_lanes();
    logic [511:0] first;
    set_defaults();
    vl_sel = 2'b01;
    sel_imm = 8'b0000_0001; fire("R3");
    first = res;
    chk_vec("R7", {256'h0, 256'h0} | (res & {256'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 256'h0}), '0);
    sel_imm = 8'b1111_1101; fire("R3");
    chk_vec("R3", res, first);
    sel_imm = 8'b1010_1110; fire("R3");
  endtask

  task automatic t_bcast();
    set_defaults();
    sel_imm = 8'b11_01_10_00;
    bcast = 1; b_from_mem = 1; esz_64 = 0; fire("R4");
    esz_64 = 1; fire("R4");
    b_from_mem = 0; fire("R4");
    vl_sel = 2'b01; b_from_mem = 1; sel_imm = 8'h03; fire("R4");
  endtask

  task automatic t_mask();
    set_defaults();
    sel_imm = 8'b00_01_10_11; mask_en = 1;
    wmask = 16'hA5C3; zero_mode = 0; esz_64 = 0; fire("R6");
    zero_mode = 1; fire("R6");
    wmask = 16'h005A; esz_64 = 1; zero_mode = 0; fire("R5");
    zero_mode = 1; fire("R5");
    wmask = 16'h0000; fire("R6");
    mask_en = 0; wmask = 16'h0000; zero_mode = 1; fire("R6");
  endtask

  task automatic t_upper_mask_bits();
    logic [511:0] base;
    set_defaults();
    vl_sel = 2'b01; mask_en = 1; sel_imm = 8'h02;
    wmask = 16'h0036; fire("R5");
    base = res;
    wmask = 16'hFF36; fire("R5");
    chk_vec("R5", res, base);
    esz_64 = 1; wmask = 16'h0005; fire("R5");
    base = res;
    wmask = 16'hFFF5; fire("R5");
    chk_vec("R5", res, base);
  endtask

  task automatic t_esize_neutral();
    logic [511:0] r32;
    set_defaults();
    sel_imm = 8'b10_00_11_01; esz_64 = 0; fire("R11");
    r32 = res;
    esz_64 = 1; fire("R11");
    chk_vec("R11", res, r32);
  endtask

  task automatic t_illegal();
    logic [511:0] held;
    set_defaults();
    sel_imm = 8'h1B; fire("R9");
    held = res;
    for (int c = 0; c < 2; c++) begin
      vl_sel = (c == 0) ? 2'b00 : 2'b11;
      sel_imm = 8'hE4;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk_bit("R8", "len_err", len_err, 1'b1);
      chk_bit("R8", "res_valid", res_valid, 1'b0);
      chk_vec("R8", res, held);
      @(negedge clk);
      chk_bit("R8", "len_err clears", len_err, 1'b0);
    end
  endtask

  task automatic t_timing();
    logic [511:0] held;
    set_defaults();
    sel_imm = 8'h4E; fire("R9");
    held = res;
    sel_imm = 8'hB1;
    @(negedge clk);
    chk_bit("R9", "res_valid drops", res_valid, 1'b0);
    chk_vec("R9", res, held);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_full_lanes();
        t_half_lanes();
        t_bcast();
        t_mask();
        t_upper_mask_bits();
        t_esize_neutral();
        t_illegal();
        t_timing();
      end
      begin
        repeat (20000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule